// File: doc/BRIEF.md
# Chained-Word SPI Master

An SPI master (mode 0) that shifts one command word at a time. Every command carries its own controls: a bit count from 1 to 16, which of four active-low selects to drive, an end-of-transfer flag and an end-of-frame flag. A long logical frame is built by issuing several shorter words back to back. The select stays asserted between them for as long as end-of-transfer is clear, even when the next word arrives late.

Commands enter on a valid/ready port that holds one word. Each received word leaves on `rx_data`, right-aligned, together with a one-cycle `rx_valid` pulse. The SCK rate comes from the `div` input. The `gap` input sets how many idle SCK periods follow a word that ends a frame. During that pause the select is held.

Top module: `spi_chain_master`

## Requirements
- R1: While reset is held and directly after it, all of `ss_n` are high, `sck` is low, `rx_valid` is low and `cmd_ready` is high.
- R2: `cmd_len` holds the bit count minus one (0 means 1 bit, 15 means 16 bits). The word produces exactly that many SCK pulses and sends `cmd_data[cmd_len:0]` starting with bit `cmd_len`.
- R3: Each SCK half period lasts `div`+1 clock cycles and SCK idles low. MOSI changes only when SCK falls or a word is loaded. MISO is sampled in the clock cycle in which SCK rises.
- R4: The bits received for a word appear right-aligned in `rx_data` with the upper bits zero. `rx_valid` is high for exactly one cycle, the cycle after that word's last SCK fall.
- R5: `cmd_ready` is high only when the block is idle or is waiting with a select held. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- R6: `cmd_sel` (0 to 3) drives `ss_n[cmd_sel]` low. At most one select is low at any time.
- R7: A select goes low `div`+1 cycles before the first SCK rise of a word. It stays low for at least `div`+1 cycles after the last SCK fall.
- R8: After a word with end-of-transfer clear, the select stays low without limit until the next command, however late that command comes.
- R9: After a word with end-of-transfer set, the select goes high once the hold delay has passed, and the block returns to idle.
- R10: A frame longer than 16 bits (for example 8+16, 12+12 or 16+16+8) is sent as chained words, and the select stays low for the whole frame.
- R11: A word with end-of-frame set and end-of-transfer clear is followed by 2·`gap`·(`div`+1) cycles with SCK low, the select held and `cmd_ready` low. With `gap` = 0 there is no pause. End-of-frame never releases the select.
- R12: If the next word selects a different slave while end-of-transfer was clear, all selects go high for `div`+1 cycles before the new select goes low.
- R13: If end-of-transfer and end-of-frame are both set, end-of-transfer takes precedence: the select is released and no pause is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div | input | 8 | SCK divider; half period is div+1 clocks |
| gap | input | 4 | Idle SCK periods after an end-of-frame word |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken |
| cmd_data | input | 16 | Transmit bits, right-aligned |
| cmd_len | input | 4 | Bit count minus one |
| cmd_sel | input | 2 | Select to drive |
| cmd_eot | input | 1 | End of transfer: release select after word |
| cmd_eof | input | 1 | End of frame: insert idle pause after word |
| rx_valid | output | 1 | One-cycle pulse, received word ready |
| rx_data | output | 16 | Received bits, right-aligned |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low slave selects |

## Verification
Two controls can fall on the same word: end-of-transfer and end-of-frame. A word is issued with both flags set and a nonzero gap. The expected result is that the select is released after the hold delay with no idle pause. A second case is the handshake landing in the first cycle `cmd_ready` rises: the next command is kept valid throughout, so it is accepted in that first ready cycle, including when it switches to a different select. A behavioural model in the bench predicts `ss_n`, `sck`, `mosi`, `cmd_ready` and `rx_valid`/`rx_data` for every clock cycle, and the bench compares the design against it on each cycle.

// File: rtl/spi_chain_master.sv
module spi_chain_master #(
  parameter int DIV_W = 8,
  parameter int GAP_W = 4,
  parameter int NSEL  = 4,
  parameter int WMAX  = 16,
  localparam int SEL_W = $clog2(NSEL),
  localparam int LEN_W = $clog2(WMAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic [GAP_W-1:0] gap,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [WMAX-1:0]  cmd_data,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic             cmd_eot,
  input  logic             cmd_eof,
  output logic             rx_valid,
  output logic [WMAX-1:0]  rx_data,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NSEL-1:0]  ss_n
);

  typedef enum logic [2:0] {IDLE, SWAP, SETUP, SHIFT, HOLD, PAUSE, WAIT} st_t;

  st_t              st;
  logic [DIV_W-1:0] cnt;
  logic [GAP_W:0]   gcnt;
  logic [LEN_W-1:0] left;
  logic [WMAX-1:0]  tx_sh, rx_sh;
  logic [SEL_W-1:0] cur_sel;
  logic             cur_eot, cur_eof;

  wire tick   = (cnt == div);
  wire accept = cmd_valid && cmd_ready;

  assign cmd_ready = (st == IDLE) || (st == WAIT);
  assign mosi      = tx_sh[WMAX-1];
  assign ss_n      = (st == IDLE || st == SWAP) ? '1 : ~(NSEL'(1) << cur_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      gcnt     <= '0;
      left     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      cur_sel  <= '0;
      cur_eot  <= 1'b0;
      cur_eof  <= 1'b0;
      sck      <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      cnt <= (st == IDLE || st == WAIT || tick) ? '0 : cnt + 1'b1;
      if (accept) begin
        tx_sh   <= cmd_data << (LEN_W'(WMAX-1) - cmd_len);
        left    <= cmd_len;
        rx_sh   <= '0;
        cur_sel <= cmd_sel;
        cur_eot <= cmd_eot;
        cur_eof <= cmd_eof;
      end
      case (st)
        IDLE:  if (accept) st <= SETUP;
        WAIT:  if (accept) st <= (cmd_sel == cur_sel) ? SETUP : SWAP;
        SWAP:  if (tick) st <= SETUP;
        SETUP: if (tick) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[WMAX-2:0], miso};
          st    <= SHIFT;
        end
        SHIFT: if (tick) begin
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[WMAX-2:0], miso};
          end else begin
            sck <= 1'b0;
            if (left == '0) begin
              st       <= HOLD;
              rx_valid <= 1'b1;
              rx_data  <= rx_sh;
            end else begin
              left  <= left - 1'b1;
              tx_sh <= tx_sh << 1;
            end
          end
        end
        HOLD: if (tick) begin
          if (cur_eot) st <= IDLE;
          else if (cur_eof && gap != '0) begin
            gcnt <= {gap, 1'b0};
            st   <= PAUSE;
          end else st <= WAIT;
        end
        PAUSE: if (tick) begin
          if (gcnt == 1) st <= WAIT;
          gcnt <= gcnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_one_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ss_n));

  assert_sck_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_n == '1) |-> !sck);

  assert_ready_sck_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !sck);

  assert_rx_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_wait_holds_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WAIT) |-> (ss_n != '1));

  assert_no_direct_switch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ss_n) != '1 && ss_n != '1) |-> (ss_n == $past(ss_n)));

  assert_sck_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) |-> $past(tick));

endmodule

// File: tb/spi_chain_master_test.sv
module spi_chain_master_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] PAT = 32'h9E37_79B9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] div = 8'd1;
  logic [3:0] gap = 4'd0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [15:0] cmd_data = '0;
  logic [3:0] cmd_len = '0;
  logic [1:0] cmd_sel = '0;
  logic cmd_eot = 1'b0, cmd_eof = 1'b0;
  logic rx_valid, sck, mosi;
  logic [15:0] rx_data;
  logic miso;
  logic [3:0] ss_n;

  int checks = 0, fails = 0;
  int scount = 0;
  bit model_on = 0;
  logic [3:0] e_ss = '1;
  logic e_sck = 0, e_ready = 1, e_rxv = 0, e_mosi = 0;
  logic [15:0] e_rx = '0;

  spi_chain_master uut (
    .clk(clk), .rst_n(rst_n), .div(div), .gap(gap),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_len(cmd_len), .cmd_sel(cmd_sel), .cmd_eot(cmd_eot), .cmd_eof(cmd_eof),
    .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n)
  );

  always #(CLK_P/2) clk = ~clk;

  initial miso = PAT[0];
  always @(negedge sck) begin
    scount = scount + 1;
    miso = PAT[scount % 32];
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    check(ss_n == e_ss, "R6 R7 R8 R9 R10 R12 R13 ss_n", ss_n, e_ss);
    check(sck == e_sck, "R2 R3 sck", sck, e_sck);
    check(cmd_ready == e_ready, "R5 R11 cmd_ready", cmd_ready, e_ready);
    check(rx_valid == e_rxv, "R4 rx_valid", rx_valid, e_rxv);
    if (e_rxv) check(rx_data == e_rx, "R4 rx_data", rx_data, e_rx);
    if (e_ss != '1) check(mosi == e_mosi, "R2 R3 mosi", mosi, e_mosi);
  end

  task automatic t1;
    @(posedge clk);
    #1;
  endtask

  initial begin : model
    logic [15:0] d;
    int l, h, g;
    logic [1:0] s;
    logic eot, eof;
    logic [15:0] rx;
    bit go_idle;
    @(posedge rst_n);
    model_on = 1;
    forever begin
      e_ss = '1; e_sck = 0; e_ready = 1; e_rxv = 0;
      do t1(); while (!cmd_valid);
      d = cmd_data; l = int'(cmd_len); s = cmd_sel; eot = cmd_eot; eof = cmd_eof;
      go_idle = 0;
      while (!go_idle) begin
        h = int'(div) + 1;
        e_ss = ~(4'b1 << s); e_sck = 0; e_ready = 0; e_mosi = d[l];
        repeat (h) t1();
        rx = '0;
        for (int i = 0; i <= l; i++) begin
          e_sck = 1; e_mosi = d[l-i];
          rx = {rx[14:0], PAT[g % 32]};
          repeat (h) t1();
          e_sck = 0; g++;
          if (i < l) begin
            e_mosi = d[l-i-1];
            repeat (h) t1();
          end
        end
        e_rxv = 1; e_rx = rx;
        t1();
        e_rxv = 0;
        repeat (h-1) t1();
        if (eot) go_idle = 1;
        else begin
          if (eof && gap != 0) repeat (2*int'(gap)*h) t1();
          e_ready = 1;
          do t1(); while (!cmd_valid);
          d = cmd_data; l = int'(cmd_len); eot = cmd_eot; eof = cmd_eof;
          e_ready = 0;
          if (cmd_sel != s) begin
            e_ss = '1;
            s = cmd_sel;
            repeat (h) t1();
          end
          else s = cmd_sel;
        end
      end
    end
  end

  task automatic send(logic [15:0] dat, int nbits, logic [1:0] sel, logic eot, logic eof);
    cmd_valid = 1; cmd_data = dat; cmd_len = 4'(nbits-1); cmd_sel = sel;
    cmd_eot = eot; cmd_eof = eof;
    forever begin
      if (cmd_ready) begin
        @(posedge clk);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    cmd_valid = 0;
  endtask

  task automatic pause(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle;
    pause(400);
  endtask

  initial begin : stim
    pause(3);
    check(ss_n == 4'hF, "R1 ss_n in reset", ss_n, 4'hF);
    check(sck == 0, "R1 sck in reset", sck, 0);
    check(rx_valid == 0, "R1 rx_valid in reset", rx_valid, 0);
    check(cmd_ready == 1, "R1 cmd_ready in reset", cmd_ready, 1);
    rst_n = 1;
    pause(2);
    // R2 R4 single 8-bit word
    send(16'h00A5, 8, 2'd0, 1, 0);
    settle();
    // R8 R10 24 bits as 8+16 with a late second part
    send(16'h003C, 8, 2'd1, 0, 0);
    pause(60);
    send(16'hBEEF, 16, 2'd1, 1, 0);
    settle();
    // R11 12+12 frames with a pause
    div = 8'd2; gap = 4'd3;
    send(16'h0ABC, 12, 2'd2, 0, 0);
    send(16'h0123, 12, 2'd2, 0, 1);
    send(16'h0F0F, 12, 2'd2, 0, 0);
    send(16'h0777, 12, 2'd2, 1, 1);
    settle();
    // R2 boundary lengths
    div = 8'd1; gap = 4'd0;
    send(16'h0001, 1, 2'd3, 0, 0);
    send(16'h8001, 16, 2'd3, 1, 0);
    settle();
    // R12 select change between chained words, back-to-back
    send(16'h0055, 7, 2'd0, 0, 0);
    send(16'h002A, 6, 2'd3, 1, 0);
    settle();
    // R13 both flags, next command held valid
    gap = 4'd2;
    send(16'h1234, 16, 2'd1, 1, 1);
    send(16'h0009, 4, 2'd2, 0, 1);
    send(16'h0006, 3, 2'd2, 1, 0);
    settle();
    // R10 40-bit frame at the fastest rate
    div = 8'd0; gap = 4'd0;
    send(16'hCAFE, 16, 2'd0, 0, 0);
    send(16'hF00D, 16, 2'd0, 0, 0);
    send(16'h00E7, 8, 2'd0, 1, 1);
    settle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    #(CLK_P * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule